// File: doc/BRIEF.md
# RFID Tag Manchester Responder

This block is a synthesizable behavioural model of a passive identification tag. It takes the tag's identifier and a reader command on a parallel interface. The command carries a kind (call or sleep), a prefix value and a prefix length. When a call's prefix covers the tag's identifier and the tag is awake, the tag sends a one-bit sync header and then its identifier on a serial line in Manchester code.

Several instances are meant to drive one shared line combined by wired-OR. A reader decoding that line sees a Manchester violation wherever two responding tags differ. It can then narrow the prefix until one tag answers, and silence that tag with a sleep command. The sleep state is sticky until reset.

The bit period is a parameter in clock cycles and must be even. The line idles low, and `busy` marks the frame.

Top module: `rfid_tag_responder`

## Requirements
- R1: After reset, `line_out` and `busy` are low and the tag is awake.
- R2: A call (`cmd_valid`=1, `cmd_sleep`=0) starts a frame only if the tag is awake and not busy, and the top m bits of `tag_id` equal the top m bits of `cmd_prefix`. Here m is `cmd_len`, and any value above ID_W counts as ID_W. With m=0 every identifier matches.
- R3: A frame starts in the clock cycle after the edge that samples the call. It carries a start bit of value 1, followed by the identifier sampled at that edge, most significant bit first.
- R4: Each bit lasts BIT_CYC cycles. A 1 is high for the first BIT_CYC/2 cycles and low for the rest. A 0 is low and then high.
- R5: `busy` is high for exactly (ID_W+1)*BIT_CYC cycles per frame. `line_out` is low whenever `busy` is low.
- R6: A sleep command (`cmd_sleep`=1) accepted while the tag is not busy, with `cmd_prefix` equal to the full `tag_id`, puts the tag to sleep whatever `cmd_len` is. From then until reset, every call is ignored.
- R7: A sleep command whose prefix differs from `tag_id` in any bit has no effect. A later matching call still gets a response.
- R8: Any command that arrives while `busy` is high is ignored. The frame in progress continues unchanged, and a sleep command given then does not put the tag to sleep.
- R9: A call that does not match leaves `line_out` and `busy` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tag_id | input | ID_W | The tag's identifier |
| cmd_valid | input | 1 | A command is present in this cycle |
| cmd_sleep | input | 1 | Command kind: 0 = call, 1 = sleep |
| cmd_prefix | input | ID_W | Prefix compared with the identifier |
| cmd_len | input | $clog2(ID_W+1) | Prefix length m in bits |
| line_out | output | 1 | Manchester line, to be wired-OR with other tags |
| busy | output | 1 | High while a frame is being sent |

## Verification
Commands are driven at a falling edge and captured by the next rising edge. The first half of the start bit therefore shows on `line_out` at the following falling edge, which is frame cycle 0. In frame cycle j, the bench expects bit j/BIT_CYC of the frame, inverted when j mod BIT_CYC is at least BIT_CYC/2, with `busy` high. At cycle (ID_W+1)*BIT_CYC, both outputs are expected low again. Every sample is taken at a falling edge, one per cycle across the whole window. An ignored command is checked over the same window, so an output that never appears or changes shape mid-frame is caught at the cycle where it differs.

// File: rtl/rfid_tag_pkg.sv
package rfid_tag_pkg;
  typedef enum logic {
    CMD_CALL  = 1'b0,
    CMD_SLEEP = 1'b1
  } cmd_kind_e;

  function automatic int unsigned frame_cycles(int unsigned id_w, int unsigned bit_cyc);
    return (id_w + 1) * bit_cyc;
  endfunction
endpackage

// File: rtl/rfid_prefix_match.sv
module rfid_prefix_match #(
  parameter int ID_W  = 8,
  parameter int LEN_W = $clog2(ID_W + 1)
) (
  input  logic [ID_W-1:0]  id,
  input  logic [ID_W-1:0]  prefix,
  input  logic [LEN_W-1:0] len,
  output logic             hit,
  output logic             full_eq
);
  localparam int CMP_W = LEN_W + 1;

  logic [CMP_W-1:0] m_eff;
  logic [ID_W-1:0]  miss;

  always_comb begin
    if ({1'b0, len} > CMP_W'(ID_W)) m_eff = CMP_W'(ID_W);
    else                            m_eff = {1'b0, len};
  end

  // bit i takes part when it lies within the top m_eff positions
  for (genvar i = 0; i < ID_W; i++) begin : g_bit
    assign miss[i] = (m_eff > CMP_W'(ID_W - 1 - i)) && (id[i] != prefix[i]);
  end

  assign hit     = ~|miss;
  assign full_eq = (id == prefix);
endmodule

// File: rtl/rfid_manch_ser.sv
module rfid_manch_ser #(
  parameter int ID_W    = 8,
  parameter int BIT_CYC = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [ID_W-1:0] word,
  output logic            line,
  output logic            active
);
  localparam int FRAME_W = ID_W + 1;
  localparam int HALF    = BIT_CYC / 2;
  localparam int CNT_W   = (BIT_CYC > 1) ? $clog2(BIT_CYC) : 1;
  localparam int BIT_W   = $clog2(FRAME_W);

  logic [FRAME_W-1:0] sh_q, sh_d;
  logic [CNT_W-1:0]   cyc_q, cyc_d;
  logic [BIT_W-1:0]   left_q, left_d;
  logic               act_q, act_d;
  logic               line_q, line_d;
  logic               en;

  assign en = start | act_q;

  always_comb begin
    sh_d   = sh_q;
    cyc_d  = cyc_q;
    left_d = left_q;
    act_d  = act_q;
    line_d = line_q;
    if (start) begin
      sh_d   = {1'b1, word};
      cyc_d  = '0;
      left_d = BIT_W'(FRAME_W - 1);
      act_d  = 1'b1;
      line_d = 1'b1;
    end else if (act_q) begin
      if (cyc_q == CNT_W'(BIT_CYC - 1)) begin
        cyc_d = '0;
        if (left_q == '0) begin
          act_d  = 1'b0;
          line_d = 1'b0;
        end else begin
          sh_d   = sh_q << 1;
          left_d = left_q - 1'b1;
          line_d = sh_q[FRAME_W-2];
        end
      end else begin
        cyc_d = cyc_q + 1'b1;
        if (cyc_q == CNT_W'(HALF - 1)) line_d = ~sh_q[FRAME_W-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      cyc_q  <= '0;
      left_q <= '0;
      act_q  <= 1'b0;
      line_q <= 1'b0;
    end else if (en) begin
      sh_q   <= sh_d;
      cyc_q  <= cyc_d;
      left_q <= left_d;
      act_q  <= act_d;
      line_q <= line_d;
    end
  end

  assign line   = line_q;
  assign active = act_q;
endmodule

// File: rtl/rfid_tag_responder.sv
module rfid_tag_responder
  import rfid_tag_pkg::*;
#(
  parameter int ID_W    = 8,
  parameter int BIT_CYC = 8,
  parameter int LEN_W   = $clog2(ID_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ID_W-1:0]  tag_id,
  input  logic             cmd_valid,
  input  logic             cmd_sleep,
  input  logic [ID_W-1:0]  cmd_prefix,
  input  logic [LEN_W-1:0] cmd_len,
  output logic             line_out,
  output logic             busy
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  logic       hit, full_eq;
  logic       accept, start_tx;
  logic       asleep_q, asleep_d;
  cmd_kind_e  kind;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  rfid_prefix_match #(.ID_W(ID_W), .LEN_W(LEN_W)) u_match (
    .id      (tag_id),
    .prefix  (cmd_prefix),
    .len     (cmd_len),
    .hit     (hit),
    .full_eq (full_eq)
  );

  assign kind     = cmd_kind_e'(cmd_sleep);
  assign accept   = cmd_valid & ~busy & rst_int_n;
  assign start_tx = accept & (kind == CMD_CALL) & ~asleep_q & hit;

  always_comb begin
    asleep_d = asleep_q;
    if (accept && (kind == CMD_SLEEP) && full_eq) asleep_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) asleep_q <= 1'b0;
    else            asleep_q <= asleep_d;
  end

  rfid_manch_ser #(.ID_W(ID_W), .BIT_CYC(BIT_CYC)) u_ser (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .start  (start_tx),
    .word   (tag_id),
    .line   (line_out),
    .active (busy)
  );
endmodule

// File: rtl/rfid_tag_responder_chk.sv
module rfid_tag_responder_chk #(
  parameter int ID_W    = 8,
  parameter int BIT_CYC = 8
) (
  input logic clk,
  input logic rst_n,
  input logic line_out,
  input logic busy,
  input logic asleep_q
);
  localparam int FRAME_CYC = (ID_W + 1) * BIT_CYC;
  localparam int HALF      = BIT_CYC / 2;

  int run_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_cnt <= 0;
    else if (busy) run_cnt <= run_cnt + 1;
    else           run_cnt <= 0;
  end

  AST_IDLE_LINE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !line_out); // R5
  AST_START_BIT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> line_out); // R3
  AST_FRAME_NOT_LONG: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> run_cnt < FRAME_CYC); // R5
  AST_FRAME_NOT_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(run_cnt) == FRAME_CYC - 1); // R5
  AST_MID_BIT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    busy && (run_cnt % BIT_CYC) == HALF |-> line_out != $past(line_out)); // R4
  AST_SLEEP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    asleep_q |=> asleep_q); // R6
  AST_NO_TX_ASLEEP: assert property (@(posedge clk) disable iff (!rst_n)
    asleep_q && !busy |=> !busy); // R6
endmodule

bind rfid_tag_responder rfid_tag_responder_chk #(.ID_W(ID_W), .BIT_CYC(BIT_CYC)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .line_out (line_out),
  .busy     (busy),
  .asleep_q (asleep_q)
);

// File: tb/rfid_tag_responder_test.sv
module rfid_tag_responder_test;
  localparam int ID_W      = 8;
  localparam int BIT_CYC   = 8;
  localparam int LEN_W     = $clog2(ID_W + 1);
  localparam int HALF      = BIT_CYC / 2;
  localparam int FRAME_W   = ID_W + 1;
  localparam int FRAME_CYC = FRAME_W * BIT_CYC;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [ID_W-1:0]  tag_id;
  logic             cmd_valid;
  logic             cmd_sleep;
  logic [ID_W-1:0]  cmd_prefix;
  logic [LEN_W-1:0] cmd_len;
  logic             line_out;
  logic             busy;

  int  n_checks = 0;
  int  n_fails  = 0;
  bit  m_asleep;
  bit  done = 0;

  always #2.5 clk = ~clk;

  rfid_tag_responder #(.ID_W(ID_W), .BIT_CYC(BIT_CYC)) uut (
    .clk(clk), .rst_n(rst_n), .tag_id(tag_id), .cmd_valid(cmd_valid),
    .cmd_sleep(cmd_sleep), .cmd_prefix(cmd_prefix), .cmd_len(cmd_len),
    .line_out(line_out), .busy(busy)
  );

  function automatic bit exp_hit(logic [ID_W-1:0] id, logic [ID_W-1:0] pfx,
                                 logic [LEN_W-1:0] len);
    int m = (int'(len) > ID_W) ? ID_W : int'(len);
    for (int i = 0; i < m; i++)
      if (id[ID_W-1-i] != pfx[ID_W-1-i]) return 1'b0;
    return 1'b1;
  endfunction

  function automatic logic exp_line(logic [ID_W-1:0] id, int j);
    logic [FRAME_W-1:0] fr = {1'b1, id};
    logic b = fr[FRAME_W-1-(j / BIT_CYC)];
    return ((j % BIT_CYC) >= HALF) ? ~b : b;
  endfunction

  task automatic check(string req, logic act_l, logic exp_l, logic act_b, logic exp_b);
    n_checks++;
    if (act_l !== exp_l || act_b !== exp_b) begin
      n_fails++;
      $display("FAIL %s: line/busy got %b/%b expected %b/%b at %0t",
               req, act_l, act_b, exp_l, exp_b, $time);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_sleep = 1'b0;
    cmd_prefix = '0; cmd_len = '0;
    repeat (3) @(negedge clk);
    check("R1", line_out, 1'b0, busy, 1'b0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", line_out, 1'b0, busy, 1'b0);
    m_asleep = 1'b0;
  endtask

  // Drive one command, then check the full frame window.
  // inj_at >= 0 injects a matching sleep at that frame cycle (R8).
  task automatic run_cmd(string req, bit slp, logic [ID_W-1:0] pfx,
                         logic [LEN_W-1:0] len, int inj_at);
    bit resp;
    logic [ID_W-1:0] id = tag_id;
    resp = !slp && !m_asleep && exp_hit(id, pfx, len);
    if (slp && pfx == id) m_asleep = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_sleep = slp; cmd_prefix = pfx; cmd_len = len;
    @(negedge clk);
    cmd_valid = 1'b0;
    for (int j = 0; j <= FRAME_CYC; j++) begin
      if (resp && j < FRAME_CYC) check(req, line_out, exp_line(id, j), busy, 1'b1);
      else                       check(req, line_out, 1'b0, busy, 1'b0);
      if (resp && j == inj_at) begin
        cmd_valid = 1'b1; cmd_sleep = 1'b1; cmd_prefix = id; cmd_len = LEN_W'(ID_W);
      end else begin
        cmd_valid = 1'b0;
      end
      @(negedge clk);
    end
    cmd_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    logic [ID_W-1:0] pfx;
    int seed = 32'h5eed1234;
    void'($urandom(seed));
    tag_id = 8'b1010_0011;
    do_reset();

    // R2 R3 R4: full-length exact match
    run_cmd("R2 R3 R4", 1'b0, 8'b1010_0011, LEN_W'(8), -1);
    // R2: m=0 matches anything
    run_cmd("R2", 1'b0, 8'b0101_1100, LEN_W'(0), -1);
    // R2: partial prefix match on top 3 bits
    run_cmd("R2", 1'b0, 8'b1011_1111, LEN_W'(3), -1);
    // R9: partial prefix mismatch on the 4th bit
    run_cmd("R9", 1'b0, 8'b1011_1111, LEN_W'(4), -1);
    // R2: length above ID_W treated as ID_W
    run_cmd("R2", 1'b0, 8'b1010_0011, LEN_W'(15), -1);
    run_cmd("R9", 1'b0, 8'b1010_0010, LEN_W'(12), -1);
    // R8: matching sleep during frame ignored, next call answered
    run_cmd("R8", 1'b0, 8'b1000_0000, LEN_W'(1), 10);
    run_cmd("R8", 1'b0, 8'b1010_0011, LEN_W'(8), -1);
    // R7: sleep with one bit different has no effect
    run_cmd("R7", 1'b1, 8'b1010_0111, LEN_W'(8), -1);
    run_cmd("R7", 1'b0, 8'b1010_0011, LEN_W'(8), -1);
    // R6: sleep matches regardless of cmd_len, then calls ignored
    tag_id = 8'b0001_0001;
    run_cmd("R4", 1'b0, 8'b0000_0000, LEN_W'(0), -1);
    run_cmd("R6", 1'b1, 8'b0001_0001, LEN_W'(2), -1);
    run_cmd("R6", 1'b0, 8'b0001_0001, LEN_W'(8), -1);
    run_cmd("R6", 1'b0, 8'b0000_0000, LEN_W'(0), -1);
    // R1: reset wakes it
    do_reset();
    run_cmd("R1", 1'b0, 8'b0000_0000, LEN_W'(0), -1);

    // random phase
    for (int k = 0; k < 240; k++) begin
      int len;
      bit slp;
      if (k % 40 == 39) do_reset();
      if ($urandom_range(0, 3) == 0) tag_id = ID_W'($urandom);
      pfx = tag_id;
      if ($urandom_range(0, 2) == 0) pfx = pfx ^ ID_W'(1 << $urandom_range(0, ID_W - 1));
      len = $urandom_range(0, 15);
      slp = ($urandom_range(0, 9) == 0);
      run_cmd(slp ? "R6 R7" : "R2 R9", slp, pfx, LEN_W'(len),
              ($urandom_range(0, 3) == 0) ? int'($urandom_range(1, FRAME_CYC - 2)) : -1);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end
endmodule